// File: doc/BRIEF.md
# Word Atomic Memory Operation Unit

This block carries out the word-sized atomic memory instructions of a 32-bit RISC core: load-reserved, store-conditional and nine read-modify-write operations. The pipeline hands it a decoded instruction made up of the minor opcode, the operation selector, the destination register index, the address taken from rs1 and the data taken from rs2, together with a one-cycle start strobe. The unit then drives a single-port memory whose read data arrives one cycle after the request. When the operation has finished, it pulses done and presents the destination value along with a write enable for the register file.

The unit holds a single reservation, which records the address of the most recent load-reserved and whether that record is still valid. Any store-conditional clears it, whether that store-conditional succeeds or fails. A trap flush from the core clears it, and so does reset. For read-modify-write operations the memory port is held locked across the read cycle and the write cycle that follows it, so that no other requester can get in between them.

Top module: `amo_unit`

## Requirements
- R1: Only minor opcode 2 (funct3 = 3'b010) with a selector of 0x02 (load-reserved), 0x03 (store-conditional), 0x01 (swap), 0x00 (add), 0x04 (xor), 0x0C (and), 0x08 (or), 0x10 (signed min), 0x14 (signed max), 0x18 (unsigned min) or 0x1C (unsigned max) is an operation. Any other combination makes no memory request, leaves rdWrite low, and pulses done one cycle after start.
- R2: Load-reserved reads the word at rs1Addr and returns it on rdData. It also records rs1Addr as the reservation address and marks the reservation valid.
- R3: Store-conditional succeeds only when the reservation is valid and its address equals rs1Addr in every bit. On success it writes rs2Data to that address and returns 0.
- R4: A store-conditional that does not succeed makes no memory write and returns 1.
- R5: Every store-conditional clears the reservation, whether it succeeds or fails.
- R6: Swap, add, xor, and and or each return the original memory word on rdData and write op(old, rs2Data) back to memory. Add wraps modulo 2^32.
- R7: Min and max compare their operands as signed 32-bit values. Unsigned min and unsigned max compare them as unsigned values.
- R8: A trapFlush pulse clears the reservation. Reset also clears it.
- R9: A read-modify-write issues a read in the first cycle after start and a write to the same address in the next cycle. memLock is high in both of those cycles, and memLock never appears without memReq.
- R10: done is a one-cycle pulse. It comes 3 cycles after the start edge for load-reserved and read-modify-write operations, and 2 cycles after it for store-conditional. After reset, done, memReq and rdWrite are low.
- R11: When rdIdx is 0, rdWrite stays low, but the memory side effect still takes place. In all other cases rdWrite rises together with done for every valid operation.
- R12: A start that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept the decoded instruction (taken only when idle) |
| funct3 | input | 3 | Minor opcode; 2 selects word operations |
| funct5 | input | 5 | Atomic operation selector |
| rdIdx | input | 5 | Destination register index |
| rs1Addr | input | 32 | Memory address |
| rs2Data | input | 32 | Source operand |
| trapFlush | input | 1 | Trap or ecall entry; kills the reservation |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write enable (read when low) |
| memLock | output | 1 | Port lock across a read-modify-write |
| memAddr | output | 32 | Memory address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid one cycle after a read request |
| done | output | 1 | Operation complete pulse |
| rdWrite | output | 1 | Register file write enable for rdData |
| rdData | output | 32 | Destination value |

## Verification
On every cycle the assertions check the following: done lasts a single cycle; each write is followed by done; a locked write always comes straight after a locked read to the same address; memLock is never seen without memReq; rdWrite only appears together with done; and the cycle after a trap flush finds no valid reservation. Some behaviour can only be shown by the bench scenarios, because it depends on stored memory contents and on the history of earlier instructions. This covers the values each operation computes, the signed and unsigned comparisons, whether a store-conditional succeeds after exact-address matches, mismatches, traps and resets, and the fact that a start arriving while the unit is busy is ignored.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam logic [2:0] WORD_F3 = 3'b010;

  localparam logic [4:0] F5_ADD  = 5'h00;
  localparam logic [4:0] F5_SWAP = 5'h01;
  localparam logic [4:0] F5_LR   = 5'h02;
  localparam logic [4:0] F5_SC   = 5'h03;
  localparam logic [4:0] F5_XOR  = 5'h04;
  localparam logic [4:0] F5_OR   = 5'h08;
  localparam logic [4:0] F5_AND  = 5'h0C;
  localparam logic [4:0] F5_MIN  = 5'h10;
  localparam logic [4:0] F5_MAX  = 5'h14;
  localparam logic [4:0] F5_MINU = 5'h18;
  localparam logic [4:0] F5_MAXU = 5'h1C;

  typedef enum logic [1:0] {
    CLS_NONE,
    CLS_LR,
    CLS_SC,
    CLS_RMW
  } opClass_t;

  typedef enum logic [3:0] {
    ALU_SWAP,
    ALU_ADD,
    ALU_XOR,
    ALU_AND,
    ALU_OR,
    ALU_MIN,
    ALU_MAX,
    ALU_MINU,
    ALU_MAXU
  } aluSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchOp;
    logic issueRead;
    logic issueWrite;
    logic issueSc;
    logic captureOld;
    logic setRes;
    logic finish;
  } strobes_t;

endpackage

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  opClass_t decCls,
  output opClass_t curCls,
  output strobes_t stb,
  output logic     memLock
);

  typedef enum logic [1:0] {S_IDLE, S_ACCESS, S_MODIFY, S_FIN} state_t;

  state_t state, nextState;
  opClass_t clsQ;

  assign curCls = clsQ;

  always_comb begin
    stb       = '0;
    memLock   = 1'b0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          stb.latchOp = 1'b1;
          nextState   = (decCls == CLS_NONE) ? S_FIN : S_ACCESS;
        end
      end
      S_ACCESS: begin
        if (clsQ == CLS_SC) begin
          stb.issueSc = 1'b1;
          nextState   = S_FIN;
        end else begin
          stb.issueRead = 1'b1;
          memLock       = (clsQ == CLS_RMW);
          nextState     = S_MODIFY;
        end
      end
      S_MODIFY: begin
        stb.captureOld = 1'b1;
        stb.issueWrite = (clsQ == CLS_RMW);
        stb.setRes     = (clsQ == CLS_LR);
        memLock        = (clsQ == CLS_RMW);
        nextState      = S_FIN;
      end
      S_FIN: begin
        stb.finish = 1'b1;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      clsQ  <= CLS_NONE;
    end else begin
      state <= nextState;
      if (stb.latchOp) clsQ <= decCls;
    end
  end

endmodule

// File: rtl/amo_dp.sv
module amo_dp
  import amo_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  opClass_t          curCls,
  input  logic [2:0]        funct3,
  input  logic [4:0]        funct5,
  input  logic [REG_W-1:0]  rdIdx,
  input  logic [ADDR_W-1:0] rs1Addr,
  input  logic [XLEN-1:0]   rs2Data,
  input  logic              trapFlush,
  output opClass_t          decCls,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [XLEN-1:0]   memWdata,
  input  logic [XLEN-1:0]   memRdata,
  output logic              done,
  output logic              rdWrite,
  output logic [XLEN-1:0]   rdData
);

  localparam logic [XLEN-1:0] SC_FAIL = XLEN'(1);

  aluSel_t           decAlu, aluQ;
  logic [ADDR_W-1:0] addrQ;
  logic [XLEN-1:0]   opBQ;
  logic [REG_W-1:0]  rdQ;
  logic [XLEN-1:0]   rdVal;
  logic [XLEN-1:0]   aluOut;
  logic              resValid;
  logic [ADDR_W-1:0] resAddr;
  logic              resHit;
  logic              scGo;

  // instruction decode
  always_comb begin
    decCls = CLS_NONE;
    decAlu = ALU_SWAP;
    if (funct3 == WORD_F3) begin
      case (funct5)
        F5_LR:   decCls = CLS_LR;
        F5_SC:   decCls = CLS_SC;
        F5_SWAP: begin decCls = CLS_RMW; decAlu = ALU_SWAP; end
        F5_ADD:  begin decCls = CLS_RMW; decAlu = ALU_ADD;  end
        F5_XOR:  begin decCls = CLS_RMW; decAlu = ALU_XOR;  end
        F5_AND:  begin decCls = CLS_RMW; decAlu = ALU_AND;  end
        F5_OR:   begin decCls = CLS_RMW; decAlu = ALU_OR;   end
        F5_MIN:  begin decCls = CLS_RMW; decAlu = ALU_MIN;  end
        F5_MAX:  begin decCls = CLS_RMW; decAlu = ALU_MAX;  end
        F5_MINU: begin decCls = CLS_RMW; decAlu = ALU_MINU; end
        F5_MAXU: begin decCls = CLS_RMW; decAlu = ALU_MAXU; end
        default: decCls = CLS_NONE;
      endcase
    end
  end

  // modify stage: memRdata holds the old word
  always_comb begin
    case (aluQ)
      ALU_SWAP: aluOut = opBQ;
      ALU_ADD:  aluOut = memRdata + opBQ;
      ALU_XOR:  aluOut = memRdata ^ opBQ;
      ALU_AND:  aluOut = memRdata & opBQ;
      ALU_OR:   aluOut = memRdata | opBQ;
      ALU_MIN:  aluOut = ($signed(memRdata) < $signed(opBQ)) ? memRdata : opBQ;
      ALU_MAX:  aluOut = ($signed(memRdata) > $signed(opBQ)) ? memRdata : opBQ;
      ALU_MINU: aluOut = (memRdata < opBQ) ? memRdata : opBQ;
      ALU_MAXU: aluOut = (memRdata > opBQ) ? memRdata : opBQ;
      default:  aluOut = opBQ;
    endcase
  end

  assign resHit = resValid && !trapFlush && (resAddr == addrQ);
  assign scGo   = stb.issueSc && resHit;

  assign memReq   = stb.issueRead || stb.issueWrite || scGo;
  assign memWe    = stb.issueWrite || scGo;
  assign memAddr  = addrQ;
  assign memWdata = stb.issueWrite ? aluOut : opBQ;

  assign done    = stb.finish;
  assign rdWrite = stb.finish && (curCls != CLS_NONE) && (rdQ != '0);
  assign rdData  = rdVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aluQ  <= ALU_SWAP;
      addrQ <= '0;
      opBQ  <= '0;
      rdQ   <= '0;
      rdVal <= '0;
    end else begin
      if (stb.latchOp) begin
        aluQ  <= decAlu;
        addrQ <= rs1Addr;
        opBQ  <= rs2Data;
        rdQ   <= rdIdx;
      end
      if (stb.captureOld) rdVal <= memRdata;
      if (stb.issueSc)    rdVal <= resHit ? '0 : SC_FAIL;
    end
  end

  // single reservation; a trap outranks everything
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resAddr  <= '0;
    end else if (trapFlush || stb.issueSc) begin
      resValid <= 1'b0;
    end else if (stb.setRes) begin
      resValid <= 1'b1;
      resAddr  <= addrQ;
    end
  end

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  funct3,
  input  logic [4:0]  funct5,
  input  logic [4:0]  rdIdx,
  input  logic [31:0] rs1Addr,
  input  logic [31:0] rs2Data,
  input  logic        trapFlush,
  output logic        memReq,
  output logic        memWe,
  output logic        memLock,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  output logic        done,
  output logic        rdWrite,
  output logic [31:0] rdData
);

  strobes_t stb;
  opClass_t decCls;
  opClass_t curCls;

  amo_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .decCls  (decCls),
    .curCls  (curCls),
    .stb     (stb),
    .memLock (memLock)
  );

  amo_dp #(.XLEN(32), .ADDR_W(32), .REG_W(5)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .curCls    (curCls),
    .funct3    (funct3),
    .funct5    (funct5),
    .rdIdx     (rdIdx),
    .rs1Addr   (rs1Addr),
    .rs2Data   (rs2Data),
    .trapFlush (trapFlush),
    .decCls    (decCls),
    .memReq    (memReq),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memRdata  (memRdata),
    .done      (done),
    .rdWrite   (rdWrite),
    .rdData    (rdData)
  );

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        done,
  input logic        rdWrite,
  input logic        memReq,
  input logic        memWe,
  input logic        memLock,
  input logic [31:0] memAddr,
  input logic        trapFlush,
  input logic        resValid
);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_write_then_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |=> done);

  p_rd_with_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    rdWrite |-> done);

  p_locked_read_before_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memLock) |->
      ($past(memReq && !memWe && memLock) && (memAddr == $past(memAddr))));

  p_lock_needs_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    memLock |-> memReq);

  p_trap_kills_res_r8: assert property (@(posedge clk) disable iff (!rstN)
    trapFlush |=> !resValid);

endmodule

bind amo_unit amo_unit_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .done      (done),
  .rdWrite   (rdWrite),
  .memReq    (memReq),
  .memWe     (memWe),
  .memLock   (memLock),
  .memAddr   (memAddr),
  .trapFlush (trapFlush),
  .resValid  (uDp.resValid)
);

// File: tb/sim_amo_unit.sv
module sim_amo_unit;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  funct3 = 3'd2;
  logic [4:0]  funct5 = 5'd0;
  logic [4:0]  rdIdx = 5'd0;
  logic [31:0] rs1Addr = '0;
  logic [31:0] rs2Data = '0;
  logic        trapFlush = 1'b0;
  logic        memReq, memWe, memLock, done, rdWrite;
  logic [31:0] memAddr, memWdata, rdData;
  logic [31:0] memRdata = '0;

  logic [31:0] mem    [16];
  logic [31:0] refMem [16];
  bit          resV = 1'b0;
  logic [31:0] resA = '0;
  int          total = 0;
  int          bad = 0;

  always #(PERIOD/2) clk = ~clk;

  amo_unit u0 (
    .clk(clk), .rstN(rstN), .start(start), .funct3(funct3), .funct5(funct5),
    .rdIdx(rdIdx), .rs1Addr(rs1Addr), .rs2Data(rs2Data), .trapFlush(trapFlush),
    .memReq(memReq), .memWe(memWe), .memLock(memLock), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .done(done), .rdWrite(rdWrite),
    .rdData(rdData)
  );

  // single-port memory, read data one cycle after request
  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) mem[memAddr[5:2]] <= memWdata;
      else       memRdata <= mem[memAddr[5:2]];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refOp(input logic [4:0] f5, input logic [31:0] a, input logic [31:0] b);
    int sa, sb;
    sa = a; sb = b;
    case (f5)
      5'h01: return b;
      5'h00: return a + b;
      5'h04: return a ^ b;
      5'h0C: return a & b;
      5'h08: return a | b;
      5'h10: return (sa < sb) ? a : b;
      5'h14: return (sa > sb) ? a : b;
      5'h18: return (a < b) ? a : b;
      5'h1C: return (a > b) ? a : b;
      default: return b;
    endcase
  endfunction

  function automatic bit isRmw(input logic [4:0] f5);
    return f5 inside {5'h00, 5'h01, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14, 5'h18, 5'h1C};
  endfunction

  // one instruction with its behavioural expectations, compared every clock
  task automatic doOp(input logic [4:0] f5, input logic [2:0] f3, input logic [4:0] rd,
                      input logic [31:0] addr, input logic [31:0] val, input bit poke,
                      input string req);
    int idx, lat, expWr, wr;
    bit valid, isLr, isSc, rmw, hit;
    logic [31:0] old, expRd;
    idx   = addr[5:2];
    old   = refMem[idx];
    isLr  = (f3 == 3'd2) && (f5 == 5'h02);
    isSc  = (f3 == 3'd2) && (f5 == 5'h03);
    rmw   = (f3 == 3'd2) && isRmw(f5);
    valid = isLr || isSc || rmw;
    expWr = 0; expRd = 0; lat = 1;
    if (isLr) begin
      lat = 3; expRd = old; resV = 1'b1; resA = addr;
    end else if (isSc) begin
      lat = 2; hit = resV && (resA == addr);
      expRd = hit ? 32'd0 : 32'd1;
      if (hit) begin refMem[idx] = val; expWr = 1; end
      resV = 1'b0;
    end else if (rmw) begin
      lat = 3; expRd = old; expWr = 1;
      refMem[idx] = refOp(f5, old, val);
    end
    @(negedge clk);
    funct5 = f5; funct3 = f3; rdIdx = rd; rs1Addr = addr; rs2Data = val; start = 1'b1;
    wr = 0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 1 && !poke) start = 1'b0;
      if (k == 3) start = 1'b0;
      if (memReq && memWe) wr++;
      if (!valid) chk(!memReq, "R1 no memory request", {31'd0, memReq}, 32'd0);
      if (rmw && k == 1) chk(memReq && !memWe && memLock, "R9 locked read",
                             {29'd0, memReq, memWe, memLock}, 32'h5);
      if (rmw && k == 2) chk(memReq && memWe && memLock && memAddr == addr, "R9 locked write",
                             {29'd0, memReq, memWe, memLock}, 32'h7);
      chk(done == (k == lat), "R10 done timing", {31'd0, done}, {31'd0, (k == lat)});
      if (k == lat) begin
        chk(rdWrite == (valid && rd != 0), {req, " / R11 rdWrite"}, {31'd0, rdWrite},
            {31'd0, (valid && rd != 0)});
        if (valid && rd != 0) chk(rdData == expRd, {req, " rdData"}, rdData, expRd);
      end
    end
    chk(wr == expWr, {req, " write count"}, wr, expWr);
    chk(mem[idx] == refMem[idx], {req, " memory word"}, mem[idx], refMem[idx]);
  endtask

  task automatic doTrap();
    @(negedge clk);
    trapFlush = 1'b1;
    @(negedge clk);
    trapFlush = 1'b0;
    resV = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    resV = 1'b0;
    @(negedge clk);
    chk(!done && !memReq && !rdWrite, "R10 reset state", {29'd0, done, memReq, rdWrite}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]    = 32'h1000_0000 + i * 32'h0101_0101;
      refMem[i] = 32'h1000_0000 + i * 32'h0101_0101;
    end
    doReset();

    // R1: wrong width and unknown selector
    doOp(5'h00, 3'd3, 5'd5, 32'h08, 32'h1, 1'b0, "R1 bad funct3");
    doOp(5'h05, 3'd2, 5'd5, 32'h08, 32'h1, 1'b0, "R1 unknown funct5");

    // R2, R3, R4, R5
    doOp(5'h02, 3'd2, 5'd6, 32'h10, 32'h0, 1'b0, "R2 load-reserved");
    doOp(5'h03, 3'd2, 5'd7, 32'h10, 32'hCAFE_F00D, 1'b0, "R3 sc success");
    doOp(5'h03, 3'd2, 5'd7, 32'h10, 32'h1111_1111, 1'b0, "R5 sc after sc fails (R4)");
    doOp(5'h02, 3'd2, 5'd6, 32'h10, 32'h0, 1'b0, "R2 load-reserved again");
    doOp(5'h03, 3'd2, 5'd7, 32'h14, 32'h2222_2222, 1'b0, "R3 sc address mismatch (R4)");
    doOp(5'h03, 3'd2, 5'd7, 32'h10, 32'h3333_3333, 1'b0, "R5 failed sc cleared reservation");

    // R6
    doOp(5'h01, 3'd2, 5'd8, 32'h20, 32'hDEAD_BEEF, 1'b0, "R6 swap");
    doOp(5'h00, 3'd2, 5'd8, 32'h20, 32'h2152_4111, 1'b0, "R6 add wraps");
    doOp(5'h04, 3'd2, 5'd8, 32'h24, 32'hFFFF_0000, 1'b0, "R6 xor");
    doOp(5'h0C, 3'd2, 5'd8, 32'h28, 32'h0F0F_0F0F, 1'b0, "R6 and");
    doOp(5'h08, 3'd2, 5'd8, 32'h2C, 32'h8000_0001, 1'b0, "R6 or");

    // R7: signed versus unsigned
    doOp(5'h01, 3'd2, 5'd9, 32'h30, 32'h8000_0000, 1'b0, "R6 swap setup");
    doOp(5'h10, 3'd2, 5'd9, 32'h30, 32'h0000_0005, 1'b0, "R7 signed min");
    doOp(5'h18, 3'd2, 5'd9, 32'h30, 32'h0000_0005, 1'b0, "R7 unsigned min");
    doOp(5'h14, 3'd2, 5'd9, 32'h30, 32'hFFFF_FFFE, 1'b0, "R7 signed max");
    doOp(5'h1C, 3'd2, 5'd9, 32'h30, 32'hFFFF_FFFE, 1'b0, "R7 unsigned max");

    // R8: trap and reset
    doOp(5'h02, 3'd2, 5'd6, 32'h18, 32'h0, 1'b0, "R2 lr before trap");
    doTrap();
    doOp(5'h03, 3'd2, 5'd7, 32'h18, 32'h4444_4444, 1'b0, "R8 sc after trap fails");
    doOp(5'h02, 3'd2, 5'd6, 32'h18, 32'h0, 1'b0, "R2 lr before reset");
    doReset();
    doOp(5'h03, 3'd2, 5'd7, 32'h18, 32'h5555_5555, 1'b0, "R8 sc after reset fails");

    // R11: rd zero still performs memory effect
    doOp(5'h00, 3'd2, 5'd0, 32'h34, 32'h0000_0010, 1'b0, "R11 add to x0");
    doOp(5'h02, 3'd2, 5'd0, 32'h38, 32'h0, 1'b0, "R11 lr to x0");
    doOp(5'h03, 3'd2, 5'd0, 32'h38, 32'h6666_6666, 1'b0, "R11 sc to x0 writes");

    // R12: start held while busy
    doOp(5'h00, 3'd2, 5'd4, 32'h3C, 32'h0000_0001, 1'b1, "R12 start while busy ignored");

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule